// File: doc/BRIEF.md
# Banked Register File Decoder

This block holds the data-memory registers of a small 8-bit controller core and decodes each access to them. A 6-bit register address arrives with read and write strobes and a write byte. Reads return data in the same cycle, and writes land on the next rising clock edge. Address 0x00 has no storage of its own. It forwards the access to the location named by the low six bits of the pointer register. The top two pointer bits choose one of four banks for the general registers.

A status register steers the special-register window at 0x05–0x0F. Its two top bits choose one of three data pages. Bit 5 of the status register chooses one of two control pages, which are reached by raising the `ctlSel` input. The peripherals behind these windows are kept here as plain storage. The two fixed special registers at 0x01 and 0x02 are kept the same way.

Top module: `rbf_regfile`

## Requirements
- R1: After reset, every register reads 0x00. This includes the status register (0x03) and the pointer register (0x04).
- R2: Addresses 0x10–0x1F reach 16 common registers. Their contents do not depend on the pointer's bank bits.
- R3: Addresses 0x20–0x3F reach 32 registers in the bank chosen by pointer bits 7:6. A write in one bank is not visible from any other bank.
- R4: A read or write at address 0x00 acts on the address held in pointer bits 5:0. If that address is in the banked range, the bank bits apply.
- R5: If pointer bits 5:0 are zero, an access at address 0x00 reads 0x00 and its write changes nothing. This holds whatever the bank bits are.
- R6: Status bits 7:6 choose the data page for 0x05–0x0F: 00 is page 0, 01 is page 1, and 10 or 11 is page 2.
- R7: Data page 2 implements only slots 0x05–0x08. Control page 1 implements only slots 0x05–0x0A. An unimplemented slot reads 0x00, and a write to it leaves every register unchanged.
- R8: With `ctlSel` high, a direct address in 0x05–0x0F reaches the control page chosen by status bit 5. With `ctlSel` high, any other address, including 0x00, reads 0x00 and its write is ignored.
- R9: `rdData` is 0x00 whenever `rdEn` is low. When `rdEn` is high, `rdData` shows the addressed register in the same cycle.
- R10: The fixed registers at 0x01 and 0x02 store what is written to them. A write takes effect at the rising edge on which `wrEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Direct register address |
| ctlSel | input | 1 | Select control-page space instead of data space |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |

## Verification
A wrong bank or page field in the decoded strobe sends a write to another copy of the register. The error then appears on the next read of the intended location, in one of two ways. It can return stale data, or the copy in the sibling bank or page can change. The bench therefore reads the neighbours after each write. A pointer or status register holding a wrong value shows up at once: a direct read of 0x04 or 0x03 exposes it, and so does the data seen through 0x00 in the very next cycle. A decode that fails to reject an unimplemented slot or a zero pointer shows up as a non-zero read, either in the same cycle or on the next read of the slot it aliased.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 6;
  localparam int BANKS       = 4;
  localparam int BANK_REGS   = 32;
  localparam int COMMON_REGS = 16;
  localparam int FIXED_REGS  = 2;
  localparam int PAGE_SLOTS  = 11;
  localparam int DATA_PAGES  = 3;
  localparam int CTRL_PAGES  = 2;

  typedef enum logic [2:0] {
    RG_NONE, RG_FIXED, RG_STATUS, RG_POINTER,
    RG_PAGED, RG_CTRL, RG_COMMON, RG_BANKED
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [4:0] idx;
    logic [1:0] page;
    logic [1:0] bank;
    logic       wr;
    logic       rd;
  } rbf_strobe_t;
endpackage

// File: rtl/rbf_ctrl.sv
module rbf_ctrl
  import rbf_pkg::*;
#(
  parameter int P2_SLOTS = 4,
  parameter int C1_SLOTS = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctlSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] statusVal,
  input  logic [DATA_W-1:0] ptrVal,
  output rbf_strobe_t       strb
);
  localparam logic [3:0] P2_LIM = 4'(P2_SLOTS);
  localparam logic [3:0] C1_LIM = 4'(C1_SLOTS);

  logic              indirect;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] offWide;
  logic [3:0]        slotOff;
  logic              inWindow;

  always_comb begin
    indirect = (addr == '0);
    effAddr  = indirect ? ptrVal[ADDR_W-1:0] : addr;
    offWide  = effAddr - 6'd5;
    slotOff  = offWide[3:0];
    inWindow = (addr >= 6'd5) && (addr <= 6'd15);

    strb.region = RG_NONE;
    strb.idx    = '0;
    strb.page   = '0;
    strb.bank   = ptrVal[7:6];

    if (ctlSel) begin
      // control space: direct window addresses only
      if (inWindow) begin
        strb.page = {1'b0, statusVal[5]};
        strb.idx  = {1'b0, addr[3:0] - 4'd5};
        if (!statusVal[5] || (addr[3:0] - 4'd5) < C1_LIM) strb.region = RG_CTRL;
      end
    end else if (effAddr == '0) begin
      strb.region = RG_NONE;
    end else if (effAddr <= 6'd2) begin
      strb.region = RG_FIXED;
      strb.idx    = 5'(effAddr - 6'd1);
    end else if (effAddr == 6'd3) begin
      strb.region = RG_STATUS;
    end else if (effAddr == 6'd4) begin
      strb.region = RG_POINTER;
    end else if (effAddr <= 6'd15) begin
      strb.page = statusVal[7] ? 2'd2 : {1'b0, statusVal[6]};
      strb.idx  = {1'b0, slotOff};
      if (!statusVal[7] || slotOff < P2_LIM) strb.region = RG_PAGED;
    end else if (effAddr <= 6'd31) begin
      strb.region = RG_COMMON;
      strb.idx    = {1'b0, effAddr[3:0]};
    end else begin
      strb.region = RG_BANKED;
      strb.idx    = effAddr[4:0];
    end

    strb.wr = wrEn && (strb.region != RG_NONE);
    strb.rd = rdEn;
  end
endmodule

// File: rtl/rbf_datapath.sv
module rbf_datapath
  import rbf_pkg::*;
#(
  parameter int P2_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbf_strobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusVal,
  output logic [DATA_W-1:0] ptrVal
);
  localparam int PAGED_N = DATA_PAGES * PAGE_SLOTS;
  localparam int CTRL_N  = CTRL_PAGES * PAGE_SLOTS;

  logic [DATA_W-1:0] fixedMem  [FIXED_REGS];
  logic [DATA_W-1:0] pagedMem  [PAGED_N];
  logic [DATA_W-1:0] ctrlMem   [CTRL_N];
  logic [DATA_W-1:0] commonMem [COMMON_REGS];
  logic [DATA_W-1:0] statusReg, ptrReg;
  logic [DATA_W-1:0] bankRd    [BANKS];
  logic [5:0]        pIdx;
  logic [5:0]        cIdx;
  logic [DATA_W-1:0] muxVal;

  assign pIdx = 6'(strb.page) * 6'(PAGE_SLOTS) + 6'(strb.idx);
  assign cIdx = 6'(strb.page) * 6'(PAGE_SLOTS) + 6'(strb.idx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      ptrReg    <= '0;
      for (int i = 0; i < FIXED_REGS; i++)  fixedMem[i]  <= '0;
      for (int i = 0; i < PAGED_N; i++)     pagedMem[i]  <= '0;
      for (int i = 0; i < CTRL_N; i++)      ctrlMem[i]   <= '0;
      for (int i = 0; i < COMMON_REGS; i++) commonMem[i] <= '0;
    end else if (strb.wr) begin
      case (strb.region)
        RG_FIXED:   fixedMem[strb.idx[0]]       <= wrData;
        RG_STATUS:  statusReg                   <= wrData;
        RG_POINTER: ptrReg                      <= wrData;
        RG_PAGED:   pagedMem[pIdx]              <= wrData;
        RG_CTRL:    ctrlMem[cIdx]               <= wrData;
        RG_COMMON:  commonMem[strb.idx[3:0]]    <= wrData;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] bankMem [BANK_REGS];
    logic              bankWe;
    assign bankWe = strb.wr && (strb.region == RG_BANKED) && (strb.bank == 2'(b));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < BANK_REGS; i++) bankMem[i] <= '0;
      end else if (bankWe) begin
        bankMem[strb.idx] <= wrData;
      end
    end
    assign bankRd[b] = bankMem[strb.idx];
  end

  always_comb begin
    case (strb.region)
      RG_FIXED:   muxVal = fixedMem[strb.idx[0]];
      RG_STATUS:  muxVal = statusReg;
      RG_POINTER: muxVal = ptrReg;
      RG_PAGED:   muxVal = pagedMem[pIdx];
      RG_CTRL:    muxVal = ctrlMem[cIdx];
      RG_COMMON:  muxVal = commonMem[strb.idx[3:0]];
      RG_BANKED:  muxVal = bankRd[strb.bank];
      default:    muxVal = '0;
    endcase
    rdData = strb.rd ? muxVal : '0;
  end

  assign statusVal = statusReg;
  assign ptrVal    = ptrReg;

  a_r5_none_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.region == RG_NONE) |-> rdData == '0);
  a_r6_page_legal: assert property (@(posedge clk) disable iff (!rstN)
    (strb.region == RG_PAGED) |-> strb.page != 2'd3);
  a_r7_page2_range: assert property (@(posedge clk) disable iff (!rstN)
    (strb.region == RG_PAGED && strb.page == 2'd2) |-> strb.idx < 5'(P2_SLOTS));
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wr && strb.region == RG_POINTER) |=> $stable(ptrReg));
  a_r6_status_load: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.region == RG_STATUS) |=> statusReg == $past(wrData));
  a_r2_common_load: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.region == RG_COMMON) |=> commonMem[$past(strb.idx[3:0])] == $past(wrData));
endmodule

// File: rtl/rbf_regfile.sv
module rbf_regfile
  import rbf_pkg::*;
#(
  parameter int P2_SLOTS = 4,
  parameter int C1_SLOTS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctlSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  rbf_strobe_t       strb;
  logic [DATA_W-1:0] statusVal, ptrVal;

  rbf_ctrl #(.P2_SLOTS(P2_SLOTS), .C1_SLOTS(C1_SLOTS)) u_ctrl (
    .addr(addr), .ctlSel(ctlSel), .rdEn(rdEn), .wrEn(wrEn),
    .statusVal(statusVal), .ptrVal(ptrVal), .strb(strb)
  );

  rbf_datapath #(.P2_SLOTS(P2_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .statusVal(statusVal), .ptrVal(ptrVal)
  );

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);
endmodule

// File: tb/rbf_regfile_tb.sv
module rbf_regfile_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] addr = '0;
  logic       ctlSel = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  int         nChecks = 0, nErrors = 0;
  logic       finished = 1'b0;

  rbf_regfile u_dut (.clk(clk), .rstN(rstN), .addr(addr), .ctlSel(ctlSel),
                     .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input logic c = 1'b0);
    @(negedge clk);
    addr = a; wrData = d; ctlSel = c; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; ctlSel = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v, input logic c = 1'b0);
    @(negedge clk);
    addr = a; ctlSel = c; rdEn = 1'b1;
    #1 v = rdData;
    rdEn = 1'b0; ctlSel = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    rd(6'h03, v); chk("R1 status", v, 8'h00);
    rd(6'h04, v); chk("R1 pointer", v, 8'h00);
    rd(6'h10, v); chk("R1 common", v, 8'h00);
    rd(6'h3F, v); chk("R1 banked", v, 8'h00);
  endtask

  task automatic tCommon();
    logic [7:0] v;
    wr(6'h10, 8'hA5); wr(6'h1F, 8'h3C);
    wr(6'h04, 8'hC0);
    rd(6'h10, v); chk("R2 common bank3", v, 8'hA5);
    wr(6'h04, 8'h40);
    rd(6'h1F, v); chk("R2 common bank1", v, 8'h3C);
  endtask

  task automatic tRdIdle();
    @(negedge clk);
    addr = 6'h10; rdEn = 1'b0;
    #1 chk("R9 rdEn low", rdData, 8'h00);
  endtask

  task automatic tBanks();
    logic [7:0] v;
    for (int b = 0; b < 4; b++) begin
      wr(6'h04, 8'(b << 6));
      wr(6'h25, 8'(8'h50 + b));
    end
    for (int b = 0; b < 4; b++) begin
      wr(6'h04, 8'(b << 6));
      rd(6'h25, v); chk("R3 bank isolation", v, 8'(8'h50 + b));
    end
  endtask

  task automatic tIndirect();
    logic [7:0] v;
    wr(6'h04, 8'hAA);            // bank 2, offset 0x2A
    wr(6'h00, 8'h77);
    wr(6'h04, 8'h80);
    rd(6'h2A, v); chk("R4 indirect write bank2", v, 8'h77);
    wr(6'h04, 8'h40);
    rd(6'h2A, v); chk("R3 bank1 untouched", v, 8'h00);
    wr(6'h04, 8'h11);
    wr(6'h00, 8'h99);
    rd(6'h11, v); chk("R4 indirect to common", v, 8'h99);
    rd(6'h00, v); chk("R4 indirect read", v, 8'h99);
  endtask

  task automatic tIndirZero();
    logic [7:0] v;
    wr(6'h04, 8'h00);
    wr(6'h00, 8'hFF);
    rd(6'h00, v); chk("R5 zero ptr read", v, 8'h00);
    rd(6'h04, v); chk("R5 pointer unchanged", v, 8'h00);
    wr(6'h04, 8'hC0);
    wr(6'h00, 8'h5B);
    rd(6'h00, v); chk("R5 zero offset bank3", v, 8'h00);
    rd(6'h04, v); chk("R5 pointer kept", v, 8'hC0);
  endtask

  task automatic tPages();
    logic [7:0] v;
    wr(6'h03, 8'h00); wr(6'h07, 8'h11);
    wr(6'h03, 8'h40); wr(6'h07, 8'h22);
    wr(6'h03, 8'h80); wr(6'h07, 8'h33);
    wr(6'h03, 8'hC0);
    rd(6'h07, v); chk("R6 page2 via 11", v, 8'h33);
    wr(6'h03, 8'h00);
    rd(6'h07, v); chk("R6 page0", v, 8'h11);
    wr(6'h03, 8'h40);
    rd(6'h07, v); chk("R6 page1", v, 8'h22);
  endtask

  task automatic tUnimpl();
    logic [7:0] v;
    wr(6'h03, 8'h00); wr(6'h0C, 8'h5A);
    wr(6'h03, 8'h80); wr(6'h0C, 8'hAB);
    rd(6'h0C, v); chk("R7 page2 hole read", v, 8'h00);
    wr(6'h03, 8'h00);
    rd(6'h0C, v); chk("R7 page0 not aliased", v, 8'h5A);
    wr(6'h03, 8'h40);
    rd(6'h0C, v); chk("R7 page1 not aliased", v, 8'h00);
  endtask

  task automatic tCtrl();
    logic [7:0] v;
    wr(6'h03, 8'h00); wr(6'h06, 8'h61, 1'b1);
    wr(6'h03, 8'h20); wr(6'h06, 8'h62, 1'b1);
    rd(6'h06, v, 1'b1); chk("R8 ctrl page1", v, 8'h62);
    wr(6'h0E, 8'hEE, 1'b1);
    rd(6'h0E, v, 1'b1); chk("R7 ctrl page1 hole", v, 8'h00);
    wr(6'h03, 8'h00);
    rd(6'h06, v, 1'b1); chk("R8 ctrl page0", v, 8'h61);
    rd(6'h0E, v, 1'b1); chk("R7 ctrl page0 not aliased", v, 8'h00);
    rd(6'h06, v);       chk("R8 data page separate", v, 8'h00);
    wr(6'h10, 8'h44, 1'b1);
    rd(6'h10, v, 1'b1); chk("R8 ctl outside window", v, 8'h00);
    rd(6'h10, v);       chk("R8 common untouched", v, 8'hA5);
  endtask

  task automatic tFixed();
    logic [7:0] v;
    wr(6'h01, 8'h12); wr(6'h02, 8'h34);
    rd(6'h01, v); chk("R10 fixed 01", v, 8'h12);
    rd(6'h02, v); chk("R10 fixed 02", v, 8'h34);
    @(negedge clk); addr = 6'h01; wrData = 8'hFF; wrEn = 1'b0;
    rd(6'h01, v); chk("R10 no write without wrEn", v, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tCommon();
    tRdIdle();
    tBanks();
    tIndirect();
    tIndirZero();
    tPages();
    tUnimpl();
    tCtrl();
    tFixed();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule